// File: doc/BRIEF.md
# Start-Byte Serial Register Interface

This block is a serial slave that gives a host access to a controller's index register, its status register and its pixel memory port over four wires. The host pulls the chip select low, clocks bits on a serial clock and shifts data in on one line and out on another. The first byte of every transfer addresses the device. It carries a fixed five-bit device code, an identity bit that must match a strap pin, a register-select bit and a direction bit. Two devices with different strap levels can therefore share one bus.

After a matching start byte, a write transfer packs each following pair of bytes into a 16-bit word, upper byte first, and presents it to the internal port with a one-cycle strobe. A read transfer fetches words from the internal port and shifts them back, upper byte first. Pixel memory reads are preceded by a fixed run of dummy bytes. A start byte that does not match makes the block ignore the rest of the transfer. Raising chip select ends any transfer at once.

The serial pins are sampled in the system clock domain through synchronizers. SCL edges are detected there, so SCL must stay well below the system clock rate.

Top module: `start_byte_serial_if`

## Requirements
- R1: A transfer starts when `csb_i` falls. The first byte, MSB first, is the start byte. Bits 7..3 must equal `DEV_CODE` (default 01110) and bit 2 must equal `id_strap_i`, otherwise the transfer is not served. Bit 1 is register select (0 = index on write / status on read, 1 = control or pixel data). Bit 0 is direction (1 = read, 0 = write).
- R2: After a start byte that does not match, no `wr_stb_o` or `rd_req_o` pulse occurs and `sdo_o` stays low until `csb_i` rises.
- R3: In a write transfer, each pair of bytes after the start byte forms one word, with the first byte as bits 15..8. Each completed word gives exactly one single-cycle `wr_stb_o` pulse, with `wr_data_o` holding the word and `wr_rs_o` holding the register-select bit.
- R4: A single trailing byte that is left unpaired when `csb_i` rises produces no strobe.
- R5: In a read transfer with register select 0, the byte following the start byte is already the upper byte of the first word. Each word is taken from `rd_data_i` in the cycle `rd_req_o` is high, with `rd_rs_o` equal to the register-select bit. The request for a word is made as soon as the byte before it completes, so a transfer that reads N whole words makes N+1 requests.
- R6: In a read transfer with register select 1, the first `DUMMY_BYTES` bytes (default 5) after the start byte read as 0x00, and no request is made during them. The first word is requested when the last dummy byte completes, and valid data starts with the next byte.
- R7: Read data is shifted out MSB first. `sdo_o` changes only after a falling edge of SCL, so it is stable whenever the host samples on a rising edge.
- R8: Raising `csb_i` at any point clears the bit and byte counters. The next start byte is decoded correctly even after a transfer was cut off mid-byte or during dummy bytes.
- R9: `sdo_o` is low whenever chip select is inactive and throughout write transfers.
- R10: After reset, `sdo_o`, `wr_stb_o` and `rd_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_strap_i | input | 1 | Identity level the start byte bit 2 must match |
| csb_i | input | 1 | Chip select, active low |
| scl_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in, sampled on rising SCL |
| sdo_o | output | 1 | Serial data out, updated after falling SCL |
| wr_stb_o | output | 1 | One-cycle strobe per completed write word |
| wr_rs_o | output | 1 | Register select for the written word |
| wr_data_o | output | 16 | Completed write word |
| rd_req_o | output | 1 | Read word request; `rd_data_i` taken this cycle |
| rd_rs_o | output | 1 | Register select for the requested word |
| rd_data_i | input | 16 | Read word from the internal port |

## Verification
The bench targets start bytes that are wrong in only the device code or only the identity bit. A design that decoded either one loosely would emit strobes or requests, or drive data onto `sdo_o`. Transfers are cut off mid-byte, after an unpaired byte and during the dummy run. A design that kept its counters across chip select would misframe the next start byte or strobe a half word. Memory and status reads are compared byte by byte against a model of the request stream. An off-by-one dummy count, a swapped byte order or a missed prefetch each show up as a wrong byte at a known position.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    ST_START  = 2'd0,
    ST_WRITE  = 2'd1,
    ST_READ   = 2'd2,
    ST_IGNORE = 2'd3
  } frame_st_e;
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sbs_rx.sv
module sbs_rx
  import sbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              scl_rise_i,
  input  logic              sdi_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else if (!cs_act_i) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (scl_rise_i) begin
        shreg   <= {shreg[BYTE_W-3:0], sdi_i};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {shreg, sdi_i};
        end
      end
    end
  end

  // R8: chip select release clears framing
  a_r8_cs_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (bit_cnt == '0 && !byte_vld_o));

  a_r3_byte_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter logic [4:0]  DEV_CODE    = 5'b01110,
  parameter int unsigned DUMMY_BYTES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              id_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              wr_stb_o,
  output logic              wr_rs_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic              rd_rs_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  localparam int unsigned DUM_W = $clog2(DUMMY_BYTES + 1) > 0 ? $clog2(DUMMY_BYTES + 1) : 1;
  localparam logic [DUM_W-1:0] DUM_RELOAD = DUM_W'(DUMMY_BYTES > 0 ? DUMMY_BYTES - 1 : 0);

  frame_st_e         state;
  logic              rs_q, next_hi;
  logic [DUM_W-1:0]  dummy_cnt;
  logic [BYTE_W-1:0] upper_q, lo_hold;
  logic              hit, fetch_now, dummy_now, lo_now;

  assign hit = (byte_i[7:3] == DEV_CODE) && (byte_i[2] == id_i);

  always_comb begin
    fetch_now = 1'b0;
    dummy_now = 1'b0;
    lo_now    = 1'b0;
    if (byte_vld_i && cs_act_i) begin
      unique case (state)
        ST_START: if (hit && byte_i[0]) begin
          if (byte_i[1] && DUMMY_BYTES > 0) dummy_now = 1'b1;
          else                              fetch_now = 1'b1;
        end
        ST_READ: begin
          if (dummy_cnt != '0) dummy_now = 1'b1;
          else if (next_hi)    fetch_now = 1'b1;
          else                 lo_now    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign tx_load_o = fetch_now | dummy_now | lo_now;
  assign tx_byte_o = fetch_now ? rd_data_i[WORD_W-1:BYTE_W] : (lo_now ? lo_hold : '0);
  assign rd_req_o  = fetch_now;
  assign rd_rs_o   = (state == ST_START) ? byte_i[1] : rs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_START;
      rs_q      <= 1'b0;
      next_hi   <= 1'b1;
      dummy_cnt <= '0;
      upper_q   <= '0;
      lo_hold   <= '0;
      wr_stb_o  <= 1'b0;
      wr_rs_o   <= 1'b0;
      wr_data_o <= '0;
    end else if (!cs_act_i) begin
      state     <= ST_START;
      next_hi   <= 1'b1;
      dummy_cnt <= '0;
      wr_stb_o  <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      if (fetch_now) begin
        lo_hold <= rd_data_i[BYTE_W-1:0];
        next_hi <= 1'b0;
      end
      if (lo_now) next_hi <= 1'b1;
      if (byte_vld_i) begin
        unique case (state)
          ST_START: begin
            if (hit) begin
              rs_q  <= byte_i[1];
              state <= byte_i[0] ? ST_READ : ST_WRITE;
              if (dummy_now) dummy_cnt <= DUM_RELOAD;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_WRITE: begin
            if (next_hi) begin
              upper_q <= byte_i;
              next_hi <= 1'b0;
            end else begin
              wr_stb_o  <= 1'b1;
              wr_rs_o   <= rs_q;
              wr_data_o <= {upper_q, byte_i};
              next_hi   <= 1'b1;
            end
          end
          ST_READ: if (dummy_now) dummy_cnt <= dummy_cnt - 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r3_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  a_r2_ignore_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE) |-> (!rd_req_o && !wr_stb_o));

  a_r5_req_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> (state == ST_READ));

  a_r6_no_req_in_dummy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_READ && dummy_cnt != '0) |-> !rd_req_o);
endmodule

// File: rtl/sbs_tx.sv
module sbs_tx
  import sbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              scl_fall_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              sdo_o
);
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg <= '0;
      sdo_o <= 1'b0;
    end else if (!cs_act_i) begin
      shreg <= '0;
      sdo_o <= 1'b0;
    end else if (load_i) begin
      shreg <= byte_i;
    end else if (scl_fall_i) begin
      sdo_o <= shreg[BYTE_W-1];
      shreg <= {shreg[BYTE_W-2:0], 1'b0};
    end
  end

  // R7: output moves only on a falling SCL
  a_r7_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_i && !scl_fall_i) |=> $stable(sdo_o));

  // R9: idle level while deselected
  a_r9_sdo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !sdo_o);
endmodule

// File: rtl/start_byte_serial_if.sv
module start_byte_serial_if
  import sbs_pkg::*;
#(
  parameter logic [4:0]  DEV_CODE    = 5'b01110,
  parameter int unsigned DUMMY_BYTES = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_strap_i,
  input  logic              csb_i,
  input  logic              scl_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              wr_stb_o,
  output logic              wr_rs_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic              rd_rs_o,
  input  logic [WORD_W-1:0] rd_data_i
);
  logic [2:0]        pins_s;
  logic              csb_s, scl_s, sdi_s, scl_q;
  logic              cs_act, scl_rise, scl_fall;
  logic              byte_vld, tx_load;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  sbs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i, .rst_ni,
    .d_i ({csb_i, scl_i, sdi_i}),
    .q_o (pins_s)
  );
  assign {csb_s, scl_s, sdi_s} = pins_s;
  assign cs_act = ~csb_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b0;
    else         scl_q <= scl_s;
  end
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

  sbs_rx i_rx (
    .clk_i, .rst_ni,
    .cs_act_i   (cs_act),
    .scl_rise_i (scl_rise),
    .sdi_i      (sdi_s),
    .byte_vld_o (byte_vld),
    .byte_o     (rx_byte)
  );

  sbs_ctrl #(.DEV_CODE(DEV_CODE), .DUMMY_BYTES(DUMMY_BYTES)) i_ctrl (
    .clk_i, .rst_ni,
    .cs_act_i   (cs_act),
    .id_i       (id_strap_i),
    .byte_vld_i (byte_vld),
    .byte_i     (rx_byte),
    .wr_stb_o, .wr_rs_o, .wr_data_o,
    .rd_req_o, .rd_rs_o, .rd_data_i,
    .tx_load_o  (tx_load),
    .tx_byte_o  (tx_byte)
  );

  sbs_tx i_tx (
    .clk_i, .rst_ni,
    .cs_act_i   (cs_act),
    .scl_fall_i (scl_fall),
    .load_i     (tx_load),
    .byte_i     (tx_byte),
    .sdo_o
  );

  a_r10_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!wr_stb_o && !rd_req_o && !sdo_o));
endmodule

// File: tb/test_start_byte_serial_if.sv
module test_start_byte_serial_if;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_strap = 1'b0;
  logic        csb = 1'b1, scl = 1'b0, sdi = 1'b0;
  logic        sdo, wr_stb, wr_rs, rd_req, rd_rs;
  logic [15:0] wr_data, rd_data;

  always #10 clk = ~clk;

  start_byte_serial_if i_start_byte_serial_if (
    .clk_i(clk), .rst_ni(rst_n), .id_strap_i(id_strap),
    .csb_i(csb), .scl_i(scl), .sdi_i(sdi), .sdo_o(sdo),
    .wr_stb_o(wr_stb), .wr_rs_o(wr_rs), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_rs_o(rd_rs), .rd_data_i(rd_data)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [16:0] wr_q[$];
  int rd_idx = 0, exp_idx = 0;
  bit req_ok = 1'b0, exp_rs = 1'b0;

  function automatic logic [15:0] word_at(int i);
    return 16'hA5C3 ^ 16'(i * 16'h1357);
  endfunction

  function automatic logic [7:0] sb(logic id, logic rs, logic rw);
    return {5'b01110, id, rs, rw};
  endfunction

  assign rd_data = word_at(rd_idx);
  always @(posedge clk) if (rd_req) rd_idx <= rd_idx + 1;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (wr_q.size() == 0) chk(1'b0, "R3/R2 unexpected write strobe", {15'd0, wr_rs, wr_data}, 0);
      else begin
        logic [16:0] e;
        e = wr_q.pop_front();
        chk({wr_rs, wr_data} === e, "R3 write word", {15'd0, wr_rs, wr_data}, {15'd0, e});
      end
    end
    if (rst_n && rd_req)
      chk(req_ok && rd_rs === exp_rs, "R5/R2 read request", {30'd0, req_ok, rd_rs}, {31'd1, exp_rs});
  end

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_low();
    csb = 1'b0; half();
  endtask

  task automatic cs_high();
    half(); csb = 1'b1; half(); half();
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sdi = tx[i];
      half();
      rx[i] = sdo;
      scl = 1'b1;
      half();
      scl = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    xfer_bits(b, 8, r);
  endtask

  task automatic expect_byte(input logic [7:0] e, input string tag);
    logic [7:0] r;
    xfer_bits(8'h00, 8, r);
    chk(r === e, tag, r, e);
  endtask

  task automatic wr_word(input logic rs, input logic [15:0] d);
    wr_q.push_back({rs, d});
    send(d[15:8]);
    send(d[7:0]);
  endtask

  task automatic rd_txn(input logic rs, input int nw);
    req_ok = 1'b1; exp_rs = rs;
    cs_low();
    send(sb(1'b0, rs, 1'b1));
    if (rs) repeat (5) expect_byte(8'h00, "R6 dummy byte");
    for (int w = 0; w < nw; w++) begin
      logic [15:0] e;
      e = word_at(exp_idx); exp_idx++;
      expect_byte(e[15:8], rs ? "R6 first valid upper" : "R5 upper byte");
      expect_byte(e[7:0],  "R5/R7 lower byte");
    end
    exp_idx++; // prefetch after final byte
    cs_high();
    req_ok = 1'b0;
    chk(rd_idx == exp_idx, "R5 request count", rd_idx, exp_idx);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog R1 act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk(sdo === 1'b0 && wr_stb === 1'b0 && rd_req === 1'b0, "R10 in reset",
        {sdo, wr_stb, rd_req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sdo === 1'b0 && wr_stb === 1'b0 && rd_req === 1'b0, "R10 after reset",
        {sdo, wr_stb, rd_req}, 0);

    // R1/R3: index write, then data writes
    cs_low(); send(sb(1'b0, 1'b0, 1'b0)); wr_word(1'b0, 16'h0022); cs_high();
    cs_low(); send(sb(1'b0, 1'b1, 1'b0));
    wr_word(1'b1, 16'h1234); wr_word(1'b1, 16'hFEDC); wr_word(1'b1, 16'h8001);
    cs_high();
    chk(wr_q.size() == 0, "R3 all words strobed", wr_q.size(), 0);

    // R5: status read, R6: memory read
    rd_txn(1'b0, 2);
    rd_txn(1'b1, 2);

    // R2: bad device code, read direction set
    cs_low(); send(8'b01010_0_1_1);
    for (int k = 0; k < 6; k++) expect_byte(8'h00, "R2 sdo low after bad code");
    cs_high();
    cs_low(); send(8'b11110_0_1_0); send(8'h55); send(8'hAA); cs_high();
    chk(wr_q.size() == 0 && rd_idx == exp_idx, "R2 nothing issued", rd_idx, exp_idx);

    // R1: identity strap mismatch, then match
    id_strap = 1'b1;
    cs_low(); send(sb(1'b0, 1'b1, 1'b1));
    for (int k = 0; k < 7; k++) expect_byte(8'h00, "R1 id mismatch silent");
    cs_high();
    cs_low(); send(sb(1'b0, 1'b1, 1'b0)); send(8'h12); send(8'h34); cs_high();
    cs_low(); send(sb(1'b1, 1'b1, 1'b0)); wr_word(1'b1, 16'h5AA5); cs_high();
    chk(wr_q.size() == 0 && rd_idx == exp_idx, "R1 id match write", wr_q.size(), 0);
    id_strap = 1'b0;

    // R8: abort mid start byte, then clean write
    cs_low(); xfer_bits(sb(1'b0, 1'b1, 1'b0), 4, r); cs_high();
    cs_low(); send(sb(1'b0, 1'b0, 1'b0)); wr_word(1'b0, 16'h0C3F); cs_high();
    chk(wr_q.size() == 0, "R8 reframe after abort", wr_q.size(), 0);

    // R4: unpaired trailing byte
    cs_low(); send(sb(1'b0, 1'b1, 1'b0)); wr_word(1'b1, 16'h7E81); send(8'h99); cs_high();
    chk(wr_q.size() == 0, "R4 odd byte dropped", wr_q.size(), 0);

    // R8: abort during dummy run, then status read
    req_ok = 1'b0;
    cs_low(); send(sb(1'b0, 1'b1, 1'b1));
    expect_byte(8'h00, "R6 dummy before abort"); expect_byte(8'h00, "R6 dummy before abort");
    cs_high();
    chk(rd_idx == exp_idx, "R8 no request on aborted dummies", rd_idx, exp_idx);
    rd_txn(1'b0, 1);
    rd_txn(1'b1, 3);

    // R9: sdo low through a write transfer
    cs_low(); send(sb(1'b0, 1'b1, 1'b0));
    wr_q.push_back({1'b1, 16'hFFFF});
    xfer_bits(8'hFF, 8, r); chk(r === 8'h00, "R9 sdo low in write", r, 0);
    xfer_bits(8'hFF, 8, r); chk(r === 8'h00, "R9 sdo low in write", r, 0);
    cs_high();
    chk(sdo === 1'b0 && wr_q.size() == 0, "R9 idle after write", {31'd0, sdo}, 0);

    done = 1'b1;
    finish_run();
  end
endmodule